// File: doc/BRIEF.md
# I2C Host Register Bank and Byte FIFOs

This block is the software-facing register bank of a FIFO-based I2C host controller. A simple 32-bit register bus (address, write enable, read strobe, write data, read data) reaches it, and a separate bus sequencer drives the serial lines. The bank holds the configuration that the sequencer consumes. These are the control bits, the clock divider, the command word with a one-cycle start pulse, the data count and the NACK-ignore option. The bank also gathers the sequencer's events into sticky status flags and drives a level interrupt.

Two byte FIFOs connect software to the sequencer. Software loads outgoing bytes through a transmit data port and the sequencer pops them. The sequencer pushes incoming bytes and software pops them through a receive data port. A FIFO-status word reports both fill levels, a receive-data-present flag, a transmit-full flag and a sticky NACK flag. Each FIFO can be flushed through a control bit that reads as one until the flush is done and then clears itself. Clearing the controller-enable bit returns the controller to a clean state.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset every readable offset returns zero, irq is low, seqTxEmpty is high and seqRxFull is low.
- R2: Register offsets: 0x00 control, 0x04 divider, 0x08 status, 0x10 transmit data, 0x14 receive data, 0x18 command, 0x1C FIFO control, 0x20 FIFO status, 0x24 data count. Control keeps bit 1 (release bus), bits 3:2 (condition: 0 none, 1 start, 2 stop, 3 repeated start), bit 5 (interrupt enable) and bit 7 (enable), so it reads back as the write masked with 0xAE. The divider and the data count keep bits 7:0 and the command keeps bits 15:0. A command write raises cmdGo for exactly the one cycle after the write. Any other offset, 0x0C and 0x28 included, reads zero. Writes to read-only fields have no effect.
- R3: A write to 0x10 pushes bits 7:0 into the transmit FIFO, which holds DEPTH bytes. seqTxData shows the oldest byte and seqTxPop removes it. A write while the FIFO is full is dropped, and a pop while it is empty does nothing.
- R4: The sequencer pushes seqRxData with seqRxPush. A read of 0x14 returns the oldest byte in bits 7:0 and removes it. A read while the FIFO is empty returns zero and leaves the level at zero.
- R5: FIFO status gives the transmit level in bits 23:16 and the receive level in bits 15:8, each saturating at 255. Bit 2 is set while the receive FIFO is not empty, and bit 5 is set while the transmit FIFO is full.
- R6: In FIFO control, bit 1 flushes the receive FIFO and bit 2 flushes the transmit FIFO. Each reads one in the cycle after its write, then clears itself with its FIFO empty. Bit 0 is stored and drives cfgIgnoreNack.
- R7: seqNack sets FIFO-status bit 1 and the interrupt-pending flag. Writing one to FIFO-status bit 1 clears the NACK flag, and writing zero leaves it set.
- R8: Status bits are: bit 1 bus error (set by seqBusErr, along with pending), bit 2 interrupt pending, bit 3 arbitration lost (set by seqArbLost), bit 6 the live seqBusBusy level, and bit 7 transfer complete (set by seqDone, along with pending). Bits 1 and 2 clear when one is written to them. Bits 3 and 7 clear when zero is written to them. A status write of all zeros clears every flag.
- R9: irq equals the interrupt-pending flag ANDed with control bit 5.
- R10: Writing control with bit 7 at zero clears every status flag and the NACK flag and empties both FIFOs. While bit 7 is zero, sequencer events set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 8 | Register byte offset |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (pops the receive FIFO at 0x14) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, valid in the same cycle |
| irq | output | 1 | Interrupt request |
| cfgEnable | output | 1 | Controller enable |
| cfgRelease | output | 1 | Release-bus request |
| cfgCond | output | 2 | Manual condition select |
| cfgDivider | output | 8 | Clock divider |
| cfgCommand | output | 16 | Command word |
| cmdGo | output | 1 | One-cycle pulse after a command write |
| cfgDataCount | output | 8 | Transfer data count |
| cfgIgnoreNack | output | 1 | Sequencer should ignore a target NACK |
| seqTxPop | input | 1 | Sequencer takes the head transmit byte |
| seqTxData | output | 8 | Head transmit byte |
| seqTxEmpty | output | 1 | Transmit FIFO empty |
| seqRxPush | input | 1 | Sequencer stores a received byte |
| seqRxData | input | 8 | Received byte |
| seqRxFull | output | 1 | Receive FIFO full |
| seqNack | input | 1 | NACK event pulse |
| seqBusErr | input | 1 | Bus error event pulse |
| seqArbLost | input | 1 | Arbitration lost event pulse |
| seqDone | input | 1 | Transfer complete event pulse |
| seqBusBusy | input | 1 | Bus busy level |

## Verification
Read data, FIFO heads and full/empty flags are combinational from state, so they are sampled in the same cycle the strobe is driven, one time step after it is set. Every write, push, pop and event takes effect at the next rising edge. The bench drives at a falling edge and samples at the following falling edge, which is the first point where the new state is visible. cmdGo and the flush-pending bits are due in exactly that one cycle after their write and must be gone one cycle later, so they are sampled at two consecutive falling edges. The FIFO sweeps compute each expected level and byte arithmetically from the loop index.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;
  localparam int BUS_AW = 8;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_CTRL  = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_DIV   = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_STAT  = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_TXD   = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_RXD   = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_CMD   = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_FCTL  = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_FSTAT = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_DCNT  = 8'h24;

  typedef struct packed {
    logic       txPush;
    logic       rxPop;
    logic       txFlush;
    logic       rxFlush;
    logic [7:0] wrByte;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_host_fifo.sv
module i2c_host_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/i2c_host_dp.sv
module i2c_host_dp
  import i2c_host_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  dpStrobe_t       stb,
  input  logic            seqTxPop,
  input  logic            seqRxPush,
  input  logic [7:0]      seqRxData,
  output logic [7:0]      txHead,
  output logic [7:0]      rxHead,
  output logic [CW-1:0]   txCount,
  output logic [CW-1:0]   rxCount,
  output logic [7:0]      txLevel,
  output logic [7:0]      rxLevel,
  output logic            txFull,
  output logic            txEmpty,
  output logic            rxFull,
  output logic            rxEmpty
);
  i2c_host_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(stb.txFlush),
    .push(stb.txPush), .pushData(stb.wrByte), .pop(seqTxPop),
    .headData(txHead), .count(txCount), .full(txFull), .empty(txEmpty)
  );

  i2c_host_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(stb.rxFlush),
    .push(seqRxPush), .pushData(seqRxData), .pop(stb.rxPop),
    .headData(rxHead), .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  generate
    if (CW > 8) begin : g_sat
      assign txLevel = (txCount > CW'(255)) ? 8'hFF : txCount[7:0];
      assign rxLevel = (rxCount > CW'(255)) ? 8'hFF : rxCount[7:0];
    end else begin : g_ext
      assign txLevel = 8'(txCount);
      assign rxLevel = 8'(rxCount);
    end
  endgenerate
endmodule

// File: rtl/i2c_host_ctrl.sv
module i2c_host_ctrl
  import i2c_host_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [BUS_DW-1:0] busWdata,
  output logic [BUS_DW-1:0] busRdata,
  output dpStrobe_t         stb,
  input  logic [7:0]        txLevel,
  input  logic [7:0]        rxLevel,
  input  logic              txFull,
  input  logic              rxEmpty,
  input  logic [7:0]        rxHead,
  input  logic              seqNack,
  input  logic              seqBusErr,
  input  logic              seqArbLost,
  input  logic              seqDone,
  input  logic              seqBusBusy,
  output logic              irq,
  output logic              cfgEnable,
  output logic              cfgRelease,
  output logic [1:0]        cfgCond,
  output logic              cfgIntEn,
  output logic [7:0]        cfgDivider,
  output logic [15:0]       cfgCommand,
  output logic              cmdGo,
  output logic [7:0]        cfgDataCount,
  output logic              cfgIgnoreNack,
  output logic              txRstPend,
  output logic              rxRstPend
);
  logic wrCtrl, wrDiv, wrStat, wrTxd, wrCmd, wrFctl, wrFstat, wrDcnt, rdRxd;
  logic zeroWrite, disableNow, evOk;
  logic stBusErr, stPend, stArbLost, stDone, nackFlag;
  logic setBusErr, setPend, setArb, setDone, setNack;
  logic clrBusErr, clrPend, clrArb, clrDone, clrNack;

  assign wrCtrl  = busWe && (busAddr == OFS_CTRL);
  assign wrDiv   = busWe && (busAddr == OFS_DIV);
  assign wrStat  = busWe && (busAddr == OFS_STAT);
  assign wrTxd   = busWe && (busAddr == OFS_TXD);
  assign wrCmd   = busWe && (busAddr == OFS_CMD);
  assign wrFctl  = busWe && (busAddr == OFS_FCTL);
  assign wrFstat = busWe && (busAddr == OFS_FSTAT);
  assign wrDcnt  = busWe && (busAddr == OFS_DCNT);
  assign rdRxd   = busRe && (busAddr == OFS_RXD);

  assign zeroWrite  = (busWdata == '0);
  assign disableNow = wrCtrl && !busWdata[7];
  assign evOk       = cfgEnable;

  // event sets and software clears
  assign setBusErr = evOk && seqBusErr;
  assign setPend   = evOk && (seqDone || seqBusErr || seqNack);
  assign setArb    = evOk && seqArbLost;
  assign setDone   = evOk && seqDone;
  assign setNack   = evOk && seqNack;
  assign clrBusErr = wrStat && (zeroWrite || busWdata[1]);
  assign clrPend   = wrStat && (zeroWrite || busWdata[2]);
  assign clrArb    = wrStat && !busWdata[3];
  assign clrDone   = wrStat && !busWdata[7];
  assign clrNack   = wrFstat && busWdata[1];

  // strobes toward the datapath
  always_comb begin
    stb.txPush  = wrTxd;
    stb.rxPop   = rdRxd;
    stb.txFlush = txRstPend || disableNow;
    stb.rxFlush = rxRstPend || disableNow;
    stb.wrByte  = busWdata[7:0];
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgEnable     <= 1'b0;
      cfgRelease    <= 1'b0;
      cfgCond       <= 2'd0;
      cfgIntEn      <= 1'b0;
      cfgDivider    <= 8'd0;
      cfgCommand    <= 16'd0;
      cmdGo         <= 1'b0;
      cfgDataCount  <= 8'd0;
      cfgIgnoreNack <= 1'b0;
    end else begin
      if (wrCtrl) begin
        cfgEnable  <= busWdata[7];
        cfgIntEn   <= busWdata[5];
        cfgCond    <= busWdata[3:2];
        cfgRelease <= busWdata[1];
      end
      if (wrDiv)  cfgDivider   <= busWdata[7:0];
      if (wrCmd)  cfgCommand   <= busWdata[15:0];
      if (wrDcnt) cfgDataCount <= busWdata[7:0];
      if (wrFctl) cfgIgnoreNack <= busWdata[0];
      cmdGo <= wrCmd;
    end
  end

  // self-clearing flush requests
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txRstPend <= 1'b0;
      rxRstPend <= 1'b0;
    end else begin
      if (txRstPend)                 txRstPend <= 1'b0;
      else if (wrFctl && busWdata[2]) txRstPend <= 1'b1;
      if (rxRstPend)                 rxRstPend <= 1'b0;
      else if (wrFctl && busWdata[1]) rxRstPend <= 1'b1;
    end
  end

  // sticky status flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stBusErr  <= 1'b0;
      stPend    <= 1'b0;
      stArbLost <= 1'b0;
      stDone    <= 1'b0;
      nackFlag  <= 1'b0;
    end else if (disableNow) begin
      stBusErr  <= 1'b0;
      stPend    <= 1'b0;
      stArbLost <= 1'b0;
      stDone    <= 1'b0;
      nackFlag  <= 1'b0;
    end else begin
      stBusErr  <= (stBusErr  && !clrBusErr) || setBusErr;
      stPend    <= (stPend    && !clrPend)   || setPend;
      stArbLost <= (stArbLost && !clrArb)    || setArb;
      stDone    <= (stDone    && !clrDone)   || setDone;
      nackFlag  <= (nackFlag  && !clrNack)   || setNack;
    end
  end

  assign irq = stPend && cfgIntEn;

  // read multiplexer
  always_comb begin
    unique case (busAddr)
      OFS_CTRL:  busRdata = {24'h0, cfgEnable, 1'b0, cfgIntEn, 1'b0, cfgCond, cfgRelease, 1'b0};
      OFS_DIV:   busRdata = {24'h0, cfgDivider};
      OFS_STAT:  busRdata = {24'h0, stDone, seqBusBusy, 2'b00, stArbLost, stPend, stBusErr, 1'b0};
      OFS_RXD:   busRdata = rxEmpty ? 32'h0 : {24'h0, rxHead};
      OFS_CMD:   busRdata = {16'h0, cfgCommand};
      OFS_FCTL:  busRdata = {29'h0, txRstPend, rxRstPend, cfgIgnoreNack};
      OFS_FSTAT: busRdata = {8'h0, txLevel, rxLevel, 2'b00, txFull, 2'b00, !rxEmpty, nackFlag, 1'b0};
      OFS_DCNT:  busRdata = {24'h0, cfgDataCount};
      default:   busRdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import i2c_host_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  busAddr,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irq,
  output logic        cfgEnable,
  output logic        cfgRelease,
  output logic [1:0]  cfgCond,
  output logic [7:0]  cfgDivider,
  output logic [15:0] cfgCommand,
  output logic        cmdGo,
  output logic [7:0]  cfgDataCount,
  output logic        cfgIgnoreNack,
  input  logic        seqTxPop,
  output logic [7:0]  seqTxData,
  output logic        seqTxEmpty,
  input  logic        seqRxPush,
  input  logic [7:0]  seqRxData,
  output logic        seqRxFull,
  input  logic        seqNack,
  input  logic        seqBusErr,
  input  logic        seqArbLost,
  input  logic        seqDone,
  input  logic        seqBusBusy
);
  dpStrobe_t      dpStb;
  logic [7:0]     txLevel, rxLevel, rxHead;
  logic [CW-1:0]  txCount, rxCount;
  logic           txFull, rxEmpty, cfgIntEn, txRstPend, rxRstPend;

  i2c_host_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .busWdata(busWdata),
    .busRdata(busRdata), .stb(dpStb),
    .txLevel(txLevel), .rxLevel(rxLevel), .txFull(txFull), .rxEmpty(rxEmpty),
    .rxHead(rxHead),
    .seqNack(seqNack), .seqBusErr(seqBusErr), .seqArbLost(seqArbLost),
    .seqDone(seqDone), .seqBusBusy(seqBusBusy),
    .irq(irq), .cfgEnable(cfgEnable), .cfgRelease(cfgRelease), .cfgCond(cfgCond),
    .cfgIntEn(cfgIntEn), .cfgDivider(cfgDivider), .cfgCommand(cfgCommand),
    .cmdGo(cmdGo), .cfgDataCount(cfgDataCount), .cfgIgnoreNack(cfgIgnoreNack),
    .txRstPend(txRstPend), .rxRstPend(rxRstPend)
  );

  i2c_host_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(dpStb),
    .seqTxPop(seqTxPop), .seqRxPush(seqRxPush), .seqRxData(seqRxData),
    .txHead(seqTxData), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(seqTxEmpty),
    .rxFull(seqRxFull), .rxEmpty(rxEmpty)
  );
endmodule

// File: rtl/i2c_host_regs_chk.sv
module i2c_host_regs_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic [CW-1:0] txCount,
  input logic [CW-1:0] rxCount,
  input logic          txPush,
  input logic          rxPop,
  input logic          txFlush,
  input logic          rxFlush,
  input logic          seqTxPop,
  input logic          seqRxPush,
  input logic          txRstPend,
  input logic          rxRstPend,
  input logic          seqDone,
  input logic          cfgEnable,
  input logic          cfgIntEn,
  input logic          busWe,
  input logic          irq
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CW'(DEPTH)) && (rxCount <= CW'(DEPTH))); // R3

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == CW'(DEPTH) && txPush && !seqTxPop && !txFlush) |=> (txCount == CW'(DEPTH))); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0 && rxPop && !seqRxPush && !rxFlush) |=> (rxCount == '0)); // R4

  AST_TX_FLUSH_SELFCLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txRstPend) |=> (!txRstPend && txCount == '0)); // R6

  AST_RX_FLUSH_SELFCLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxRstPend) |=> (!rxRstPend && rxCount == '0)); // R6

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && cfgEnable && cfgIntEn && !busWe) |=> irq); // R9
endmodule

bind i2c_host_regs i2c_host_regs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN),
  .txCount(txCount), .rxCount(rxCount),
  .txPush(dpStb.txPush), .rxPop(dpStb.rxPop),
  .txFlush(dpStb.txFlush), .rxFlush(dpStb.rxFlush),
  .seqTxPop(seqTxPop), .seqRxPush(seqRxPush),
  .txRstPend(txRstPend), .rxRstPend(rxRstPend),
  .seqDone(seqDone), .cfgEnable(cfgEnable), .cfgIntEn(cfgIntEn),
  .busWe(busWe), .irq(irq)
);

// File: tb/test_i2c_host_regs.sv
module test_i2c_host_regs;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq, cfgEnable, cfgRelease, cmdGo, cfgIgnoreNack;
  logic [1:0]  cfgCond;
  logic [7:0]  cfgDivider, cfgDataCount, seqTxData;
  logic [15:0] cfgCommand;
  logic        seqTxPop = 1'b0, seqRxPush = 1'b0;
  logic [7:0]  seqRxData = '0;
  logic        seqTxEmpty, seqRxFull;
  logic        seqNack = 1'b0, seqBusErr = 1'b0, seqArbLost = 1'b0, seqDone = 1'b0, seqBusBusy = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  i2c_host_regs #(.DEPTH(DEPTH)) i_i2c_host_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .cfgEnable(cfgEnable), .cfgRelease(cfgRelease), .cfgCond(cfgCond),
    .cfgDivider(cfgDivider), .cfgCommand(cfgCommand), .cmdGo(cmdGo),
    .cfgDataCount(cfgDataCount), .cfgIgnoreNack(cfgIgnoreNack),
    .seqTxPop(seqTxPop), .seqTxData(seqTxData), .seqTxEmpty(seqTxEmpty),
    .seqRxPush(seqRxPush), .seqRxData(seqRxData), .seqRxFull(seqRxFull),
    .seqNack(seqNack), .seqBusErr(seqBusErr), .seqArbLost(seqArbLost),
    .seqDone(seqDone), .seqBusBusy(seqBusBusy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  function automatic logic [31:0] fstat(input int tx, input int rx, input bit nack);
    logic [31:0] v;
    v = (32'(tx) << 16) | (32'(rx) << 8);
    if (rx > 0) v = v | 32'h4;
    if (tx >= DEPTH) v = v | 32'h20;
    if (nack) v = v | 32'h2;
    return v;
  endfunction

  function automatic logic [7:0] txPat(input int i);
    return 8'((i * 7 + 3) % 256);
  endfunction

  function automatic logic [7:0] rxPat(input int i);
    return 8'((i * 13 + 5) % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();

    // R1 reset state
    for (int a = 0; a <= 8'h28; a += 4) begin
      busRead(8'(a), d);
      chk("R1 reset readback", d, 32'h0);
    end
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx empty", {31'h0, seqTxEmpty}, 32'h1);
    chk("R1 rx full", {31'h0, seqRxFull}, 32'h0);

    // R2 control masking and outputs
    busWrite(8'h00, 32'hFFFF_FFFF);
    busRead(8'h00, d);
    chk("R2 control mask", d, 32'hAE);
    chk("R2 cfg outputs", {28'h0, cfgEnable, cfgRelease, cfgCond}, 32'hF);
    busWrite(8'h00, 32'h0000_0088);
    busRead(8'h00, d);
    chk("R2 control cond=2", d, 32'h88);
    chk("R2 cfgCond", {30'h0, cfgCond}, 32'h2);
    // R2 divider sweep
    for (int v = 0; v < 256; v++) begin
      busWrite(8'h04, 32'(v) | 32'h5A00_0000);
      chk("R2 divider port", {24'h0, cfgDivider}, 32'(v));
    end
    busRead(8'h04, d);
    chk("R2 divider readback", d, 32'hFF);
    // R2 command pulse
    busWrite(8'h18, 32'hABCD_1234);
    chk("R2 cmdGo high", {31'h0, cmdGo}, 32'h1);
    idle();
    chk("R2 cmdGo one cycle", {31'h0, cmdGo}, 32'h0);
    busRead(8'h18, d);
    chk("R2 command", d, 32'h1234);
    busWrite(8'h24, 32'h0000_01F0);
    busRead(8'h24, d);
    chk("R2 data count", d, 32'hF0);
    busWrite(8'h0C, 32'hFFFF_FFFF);
    busRead(8'h0C, d);
    chk("R2 unmapped 0x0C", d, 32'h0);
    busRead(8'h28, d);
    chk("R2 unmapped 0x28", d, 32'h0);
    busWrite(8'h20, 32'hFFFF_FFFD);
    busRead(8'h20, d);
    chk("R2 fifo status read-only", d, 32'h0);

    busWrite(8'h00, 32'hA0);

    // R3 / R5 transmit fill sweep including overflow
    for (int n = 1; n <= DEPTH + 2; n++) begin
      busWrite(8'h10, 32'hFFFF_FF00 | 32'(txPat(n)));
      busRead(8'h20, d);
      chk("R5 tx level", d, fstat((n > DEPTH) ? DEPTH : n, 0, 1'b0));
    end
    for (int i = 1; i <= DEPTH; i++) begin
      chk("R3 tx order", {24'h0, seqTxData}, {24'h0, txPat(i)});
      seqTxPop = 1'b1; idle(); seqTxPop = 1'b0;
    end
    chk("R3 tx empty after drain", {31'h0, seqTxEmpty}, 32'h1);
    seqTxPop = 1'b1; idle(); seqTxPop = 1'b0;
    busRead(8'h20, d);
    chk("R3 pop on empty", d, fstat(0, 0, 1'b0));

    // R4 / R5 receive fill and drain
    for (int n = 1; n <= DEPTH + 1; n++) begin
      seqRxData = rxPat(n); seqRxPush = 1'b1; idle(); seqRxPush = 1'b0;
      busRead(8'h20, d);
      chk("R5 rx level", d, fstat(0, (n > DEPTH) ? DEPTH : n, 1'b0));
    end
    chk("R4 rx full", {31'h0, seqRxFull}, 32'h1);
    for (int i = 1; i <= DEPTH; i++) begin
      busRead(8'h14, d);
      chk("R4 rx order", d, {24'h0, rxPat(i)});
    end
    busRead(8'h14, d);
    chk("R4 read empty", d, 32'h0);
    busRead(8'h20, d);
    chk("R4 no underflow", d, fstat(0, 0, 1'b0));

    // R6 self-clearing flushes
    for (int i = 0; i < 3; i++) busWrite(8'h10, 32'(i));
    for (int i = 0; i < 2; i++) begin
      seqRxData = 8'(i); seqRxPush = 1'b1; idle(); seqRxPush = 1'b0;
    end
    busWrite(8'h1C, 32'h7);
    busRead(8'h1C, d);
    chk("R6 flush bits pending", d, 32'h7);
    busRead(8'h1C, d);
    chk("R6 flush bits cleared", d, 32'h1);
    chk("R6 ignore nack out", {31'h0, cfgIgnoreNack}, 32'h1);
    busRead(8'h20, d);
    chk("R6 fifos emptied", d, fstat(0, 0, 1'b0));
    busWrite(8'h10, 32'h11);
    busWrite(8'h1C, 32'h2);
    idle();
    busRead(8'h20, d);
    chk("R6 rx-only flush keeps tx", d, fstat(1, 0, 1'b0));
    busWrite(8'h1C, 32'h4);
    idle();
    busRead(8'h20, d);
    chk("R6 tx flush", d, fstat(0, 0, 1'b0));

    // R7 sticky NACK
    seqNack = 1'b1; idle(); seqNack = 1'b0;
    busRead(8'h20, d);
    chk("R7 nack set", d, fstat(0, 0, 1'b1));
    busRead(8'h08, d);
    chk("R7 pending from nack", d, 32'h4);
    chk("R9 irq from nack", {31'h0, irq}, 32'h1);
    busWrite(8'h20, 32'h0);
    busRead(8'h20, d);
    chk("R7 write zero keeps nack", d, fstat(0, 0, 1'b1));
    busWrite(8'h20, 32'h2);
    busRead(8'h20, d);
    chk("R7 write one clears nack", d, fstat(0, 0, 1'b0));
    busWrite(8'h08, 32'h4);

    // R8 status flags
    seqBusErr = 1'b1; idle(); seqBusErr = 1'b0;
    busRead(8'h08, d);
    chk("R8 bus error", d, 32'h6);
    seqArbLost = 1'b1; idle(); seqArbLost = 1'b0;
    seqDone = 1'b1; idle(); seqDone = 1'b0;
    seqBusBusy = 1'b1; idle();
    busRead(8'h08, d);
    chk("R8 all flags", d, 32'hCE);
    busWrite(8'h08, 32'h8E);
    busRead(8'h08, d);
    chk("R8 w1c bits 1,2", d, 32'hC8);
    busWrite(8'h08, 32'h80);
    busRead(8'h08, d);
    chk("R8 write zero clears arb", d, 32'hC0);
    seqArbLost = 1'b1; idle(); seqArbLost = 1'b0;
    busWrite(8'h08, 32'h0);
    busRead(8'h08, d);
    chk("R8 all-zero write", d, 32'h40);
    seqBusBusy = 1'b0; idle();
    busRead(8'h08, d);
    chk("R8 busy live", d, 32'h0);

    // R9 interrupt gating
    busWrite(8'h00, 32'h80);
    seqDone = 1'b1; idle(); seqDone = 1'b0;
    chk("R9 irq masked", {31'h0, irq}, 32'h0);
    busWrite(8'h00, 32'hA0);
    chk("R9 irq enabled", {31'h0, irq}, 32'h1);
    busWrite(8'h08, 32'h84);
    chk("R9 irq cleared", {31'h0, irq}, 32'h0);

    // R10 disable resets
    busWrite(8'h10, 32'h55);
    busWrite(8'h10, 32'h66);
    seqRxData = 8'h77; seqRxPush = 1'b1; idle(); seqRxPush = 1'b0;
    seqDone = 1'b1; seqNack = 1'b1; idle(); seqDone = 1'b0; seqNack = 1'b0;
    busWrite(8'h00, 32'h20);
    busRead(8'h08, d);
    chk("R10 status cleared", d, 32'h0);
    busRead(8'h20, d);
    chk("R10 fifos and nack cleared", d, fstat(0, 0, 1'b0));
    seqBusErr = 1'b1; seqNack = 1'b1; seqDone = 1'b1; idle();
    seqBusErr = 1'b0; seqNack = 1'b0; seqDone = 1'b0;
    busRead(8'h08, d);
    chk("R10 events ignored status", d, 32'h0);
    busRead(8'h20, d);
    chk("R10 events ignored nack", d, fstat(0, 0, 1'b0));
    chk("R10 irq stays low", {31'h0, irq}, 32'h0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule